// File: doc/BRIEF.md
# Reset and Wake Cause Register

This block keeps a sticky record of why a small processor core last restarted or woke up, and tells the core where to resume fetching. Single-cycle strobes report each hardware event: power-on, supply brown-out, the external reset pin, the software reset instruction, watchdog time-out, watchdog wake-up, interrupt wake-up, clock-failure trap, trap-conflict reset and illegal-operation reset. A two-bit mode input tells the block whether the core was running, idling or sleeping when the event arrived, so the power state is recorded next to the cause.

Each event changes only the flags that belong to it; every other flag keeps its value. One cycle after any event the block pulses a load strobe and presents the new program counter. That counter is the reset vector for resets, a fixed trap vector for a clock failure, and either the interrupt's vector or the current counter plus a step for wake-ups. Software may read the flags at any time and overwrite them in a cycle with no hardware event.

Top module: `rst_cause_reg`

## Requirements
- R1: After rst_n is low, flags read 0, pc_load is 0 and pc_value is 0.
- R2: The flag word has nine bits: bit0 power-on, bit1 brown-out, bit2 external pin, bit3 software reset, bit4 watchdog, bit5 sleep, bit6 idle, bit7 trap conflict, bit8 illegal operation. In a cycle with no event, sw_we loads sw_wdata into the flags, visible on flags the next cycle.
- R3: Power-on sets bit0, clears all other flags and resumes at address 0.
- R4: Brown-out sets bit1, clears bit0, leaves the rest unchanged and resumes at address 0.
- R5: External pin reset sets bit2 and clears bits 3 and 4. It sets bit5 only if core_mode is sleep (2), sets bit6 only if core_mode is idle (1), and otherwise clears both. Modes 0 and 3 count as run. It resumes at address 0.
- R6: Software reset sets bit3, clears bits 2, 4, 5 and 6, and resumes at address 0.
- R7: Watchdog time-out sets bit4, clears bits 3, 5 and 6, and resumes at address 0.
- R8: Watchdog wake-up sets bits 4 and 5, leaves the rest unchanged, and resumes at cur_pc + 2.
- R9: Interrupt wake-up sets bit5 and resumes at int_vector when int_enabled is 1, and at cur_pc + 2 otherwise.
- R10: Clock-failure trap leaves every flag unchanged and resumes at address 4.
- R11: Trap-conflict reset sets bit7, and illegal-operation reset sets bit8. Each leaves all other flags unchanged and resumes at address 0.
- R12: Only the highest-priority event in a cycle takes effect. The order is power-on, brown-out, external, software, watchdog time-out, trap conflict, illegal operation, clock failure, watchdog wake-up, interrupt wake-up. A software write in a cycle that has an event is lost.
- R13: pc_load is high for exactly the one cycle after each event cycle. pc_value then holds the new counter until the next event. Program counter arithmetic wraps at PC_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_por | input | 1 | Power-on strobe |
| ev_bor | input | 1 | Brown-out strobe |
| ev_ext | input | 1 | External reset pin strobe |
| ev_swrst | input | 1 | Software reset instruction strobe |
| ev_wdt_to | input | 1 | Watchdog time-out strobe |
| ev_trapc | input | 1 | Trap-conflict reset strobe |
| ev_illop | input | 1 | Illegal-operation reset strobe |
| ev_clkfail | input | 1 | Clock-failure trap strobe |
| ev_wdt_wake | input | 1 | Watchdog wake-up strobe |
| ev_int_wake | input | 1 | Interrupt wake-up strobe |
| core_mode | input | 2 | 0 run, 1 idle, 2 sleep, 3 run |
| cur_pc | input | PC_W | Current program counter |
| int_enabled | input | 1 | Waking interrupt is enabled |
| int_vector | input | PC_W | Vector of the waking interrupt |
| sw_we | input | 1 | Software write enable |
| sw_wdata | input | 9 | Software write data |
| flags | output | 9 | Cause flags |
| pc_load | output | 1 | New program counter valid (one cycle) |
| pc_value | output | PC_W | New program counter |

## Verification
The bench builds the block with its defaults: a 24-bit counter, reset vector 0, trap vector 4 and a step of 2. With these values the wrap of cur_pc + 2 at the top of the 24-bit space can be reached directly. The clock-failure vector also differs from the reset vector, so a wrong vector choice is visible. Directed cases and a long stream of random coincident strobes, modes and writes drive the priority chain through every pairing.

// File: rtl/rcause_pkg.sv
package rcause_pkg;
  localparam int NFLAG = 9;
  localparam int NEV   = 10;

  // flag bit positions
  localparam int F_POR   = 0;
  localparam int F_BOR   = 1;
  localparam int F_EXT   = 2;
  localparam int F_SW    = 3;
  localparam int F_WDT   = 4;
  localparam int F_SLEEP = 5;
  localparam int F_IDLE  = 6;
  localparam int F_TRAP  = 7;
  localparam int F_ILL   = 8;

  // event index = priority rank (0 wins)
  localparam int E_POR    = 0;
  localparam int E_BOR    = 1;
  localparam int E_EXT    = 2;
  localparam int E_SWRST  = 3;
  localparam int E_WDTTO  = 4;
  localparam int E_TRAPC  = 5;
  localparam int E_ILLOP  = 6;
  localparam int E_CLKF   = 7;
  localparam int E_WWAKE  = 8;
  localparam int E_IWAKE  = 9;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_SLEEP = 2'd2,
    MODE_RUN2  = 2'd3
  } core_mode_e;

  typedef logic [NFLAG-1:0] flag_t;

  function automatic flag_t flag_bit(input int pos);
    flag_t m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rcause_arbiter.sv
module rcause_arbiter
  import rcause_pkg::*;
#(
  parameter int N = NEV
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]     = req[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req[i];
  end

  assign any = blocked[N];
endmodule

// File: rtl/rcause_next.sv
module rcause_next
  import rcause_pkg::*;
#(
  parameter int          PC_W      = 24,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC  = PC_W'(4),
  parameter int          PC_STEP   = 2
) (
  input  logic [NEV-1:0]  grant,
  input  flag_t           flags_q,
  input  logic [1:0]      core_mode,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            int_enabled,
  input  logic [PC_W-1:0] int_vector,
  input  logic            sw_we,
  input  flag_t           sw_wdata,
  output flag_t           flags_d,
  output logic [PC_W-1:0] pc_d
);
  function automatic logic [PC_W-1:0] resume_pc(input logic [PC_W-1:0] pc);
    return pc + PC_W'(PC_STEP);
  endfunction

  function automatic flag_t upd(input flag_t f, input flag_t set_m, input flag_t clr_m);
    return (f & ~clr_m) | set_m;
  endfunction

  always_comb begin
    flags_d = flags_q;
    pc_d    = RESET_VEC;
    if (grant[E_POR]) begin
      flags_d = flag_bit(F_POR);
    end else if (grant[E_BOR]) begin
      flags_d = upd(flags_q, flag_bit(F_BOR), flag_bit(F_POR));
    end else if (grant[E_EXT]) begin
      flags_d = upd(flags_q, flag_bit(F_EXT),
                    flag_bit(F_SW) | flag_bit(F_WDT) | flag_bit(F_SLEEP) | flag_bit(F_IDLE));
      if (core_mode == MODE_SLEEP) flags_d[F_SLEEP] = 1'b1;
      if (core_mode == MODE_IDLE)  flags_d[F_IDLE]  = 1'b1;
    end else if (grant[E_SWRST]) begin
      flags_d = upd(flags_q, flag_bit(F_SW),
                    flag_bit(F_EXT) | flag_bit(F_WDT) | flag_bit(F_SLEEP) | flag_bit(F_IDLE));
    end else if (grant[E_WDTTO]) begin
      flags_d = upd(flags_q, flag_bit(F_WDT),
                    flag_bit(F_SW) | flag_bit(F_SLEEP) | flag_bit(F_IDLE));
    end else if (grant[E_TRAPC]) begin
      flags_d = upd(flags_q, flag_bit(F_TRAP), '0);
    end else if (grant[E_ILLOP]) begin
      flags_d = upd(flags_q, flag_bit(F_ILL), '0);
    end else if (grant[E_CLKF]) begin
      pc_d = TRAP_VEC;
    end else if (grant[E_WWAKE]) begin
      flags_d = upd(flags_q, flag_bit(F_WDT) | flag_bit(F_SLEEP), '0);
      pc_d    = resume_pc(cur_pc);
    end else if (grant[E_IWAKE]) begin
      flags_d = upd(flags_q, flag_bit(F_SLEEP), '0);
      pc_d    = int_enabled ? int_vector : resume_pc(cur_pc);
    end else if (sw_we) begin
      flags_d = sw_wdata;
    end
  end
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcause_pkg::*;
#(
  parameter int              PC_W      = 24,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter logic [PC_W-1:0] TRAP_VEC  = PC_W'(4),
  parameter int              PC_STEP   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_por,
  input  logic            ev_bor,
  input  logic            ev_ext,
  input  logic            ev_swrst,
  input  logic            ev_wdt_to,
  input  logic            ev_trapc,
  input  logic            ev_illop,
  input  logic            ev_clkfail,
  input  logic            ev_wdt_wake,
  input  logic            ev_int_wake,
  input  logic [1:0]      core_mode,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            int_enabled,
  input  logic [PC_W-1:0] int_vector,
  input  logic            sw_we,
  input  logic [8:0]      sw_wdata,
  output logic [8:0]      flags,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_value
);
  logic [NEV-1:0]  ev_req;
  logic [NEV-1:0]  grant;
  logic            any_event;
  flag_t           flags_q, flags_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            load_q;

  always_comb begin
    ev_req           = '0;
    ev_req[E_POR]    = ev_por;
    ev_req[E_BOR]    = ev_bor;
    ev_req[E_EXT]    = ev_ext;
    ev_req[E_SWRST]  = ev_swrst;
    ev_req[E_WDTTO]  = ev_wdt_to;
    ev_req[E_TRAPC]  = ev_trapc;
    ev_req[E_ILLOP]  = ev_illop;
    ev_req[E_CLKF]   = ev_clkfail;
    ev_req[E_WWAKE]  = ev_wdt_wake;
    ev_req[E_IWAKE]  = ev_int_wake;
  end

  rcause_arbiter #(.N(NEV)) u_arb (
    .req   (ev_req),
    .grant (grant),
    .any   (any_event)
  );

  rcause_next #(
    .PC_W(PC_W), .RESET_VEC(RESET_VEC), .TRAP_VEC(TRAP_VEC), .PC_STEP(PC_STEP)
  ) u_next (
    .grant       (grant),
    .flags_q     (flags_q),
    .core_mode   (core_mode),
    .cur_pc      (cur_pc),
    .int_enabled (int_enabled),
    .int_vector  (int_vector),
    .sw_we       (sw_we),
    .sw_wdata    (sw_wdata),
    .flags_d     (flags_d),
    .pc_d        (pc_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pc_q    <= '0;
      load_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      load_q  <= any_event;
      if (any_event) pc_q <= pc_d;
    end
  end

  assign flags    = flags_q;
  assign pc_load  = load_q;
  assign pc_value = pc_q;
endmodule

// File: rtl/rcause_chk.sv
module rcause_chk
  import rcause_pkg::*;
#(
  parameter int PC_W = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NEV-1:0]  grant,
  input logic            any_event,
  input logic            sw_we,
  input logic [8:0]      sw_wdata,
  input logic [1:0]      core_mode,
  input logic [8:0]      flags,
  input logic            pc_load,
  input logic [PC_W-1:0] pc_value
);
  // R12: at most one event wins
  a_r12_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) <= 1);

  // R3: power-on leaves only its own flag
  a_r3_por_alone: assert property (@(posedge clk) disable iff (!rst_n)
    grant[E_POR] |=> flags == 9'h001 && pc_value == '0);

  // R4: brown-out sets its flag and clears power-on
  a_r4_bor_flags: assert property (@(posedge clk) disable iff (!rst_n)
    grant[E_BOR] |=> flags[F_BOR] && !flags[F_POR]);

  // R5: external reset records the sleep mode
  a_r5_ext_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    grant[E_EXT] && core_mode == 2'd2 |=> flags[F_EXT] && flags[F_SLEEP] && !flags[F_IDLE]);

  // R10: clock failure keeps flags
  a_r10_clkfail_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    grant[E_CLKF] |=> $stable(flags));

  // R2: write with no event lands
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we && !any_event |=> flags == $past(sw_wdata));

  // R13: load strobe follows events
  a_r13_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    any_event |=> pc_load);
  a_r13_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !any_event |=> !pc_load && $stable(pc_value));
endmodule

bind rst_cause_reg rcause_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .any_event (any_event),
  .sw_we     (sw_we),
  .sw_wdata  (sw_wdata),
  .core_mode (core_mode),
  .flags     (flags),
  .pc_load   (pc_load),
  .pc_value  (pc_value)
);

// File: tb/rst_cause_reg_test.sv
`timescale 1ns/1ps
module rst_cause_reg_test;
  localparam int PC_W = 24;
  localparam int PCMASK = (1 << PC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_por = 0, ev_bor = 0, ev_ext = 0, ev_swrst = 0, ev_wdt_to = 0;
  logic ev_trapc = 0, ev_illop = 0, ev_clkfail = 0, ev_wdt_wake = 0, ev_int_wake = 0;
  logic [1:0] core_mode = 0;
  logic [PC_W-1:0] cur_pc = 0;
  logic int_enabled = 0;
  logic [PC_W-1:0] int_vector = 0;
  logic sw_we = 0;
  logic [8:0] sw_wdata = 0;
  logic [8:0] flags;
  logic pc_load;
  logic [PC_W-1:0] pc_value;

  int n_tests = 0, n_fail = 0;
  int m_flags = 0, m_pc = 0, m_load = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rst_cause_reg uut (
    .clk(clk), .rst_n(rst_n), .ev_por(ev_por), .ev_bor(ev_bor), .ev_ext(ev_ext),
    .ev_swrst(ev_swrst), .ev_wdt_to(ev_wdt_to), .ev_trapc(ev_trapc), .ev_illop(ev_illop),
    .ev_clkfail(ev_clkfail), .ev_wdt_wake(ev_wdt_wake), .ev_int_wake(ev_int_wake),
    .core_mode(core_mode), .cur_pc(cur_pc), .int_enabled(int_enabled),
    .int_vector(int_vector), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .flags(flags), .pc_load(pc_load), .pc_value(pc_value)
  );

  // reference model: weights of flag bits
  localparam int POR = 1, BOR = 2, EXT = 4, SWR = 8, WDT = 16, SLP = 32, IDL = 64, TRP = 128, ILL = 256;

  task automatic model_step();
    int f;
    f = m_flags;
    m_load = 1;
    if (ev_por)           begin f = POR; m_pc = 0; end
    else if (ev_bor)      begin f = (f & ~POR) | BOR; m_pc = 0; end
    else if (ev_ext)      begin
      f = (f & ~(SWR | WDT | SLP | IDL)) | EXT;
      if (core_mode == 2) f = f | SLP;
      if (core_mode == 1) f = f | IDL;
      m_pc = 0;
    end
    else if (ev_swrst)    begin f = (f & ~(EXT | WDT | SLP | IDL)) | SWR; m_pc = 0; end
    else if (ev_wdt_to)   begin f = (f & ~(SWR | SLP | IDL)) | WDT; m_pc = 0; end
    else if (ev_trapc)    begin f = f | TRP; m_pc = 0; end
    else if (ev_illop)    begin f = f | ILL; m_pc = 0; end
    else if (ev_clkfail)  m_pc = 4;
    else if (ev_wdt_wake) begin f = f | WDT | SLP; m_pc = (int'(cur_pc) + 2) & PCMASK; end
    else if (ev_int_wake) begin
      f = f | SLP;
      m_pc = int_enabled ? int'(int_vector) : ((int'(cur_pc) + 2) & PCMASK);
    end
    else begin
      m_load = 0;
      if (sw_we) f = int'(sw_wdata);
    end
    m_flags = f;
  endtask

  task automatic check(input string req);
    n_tests++;
    if (int'(flags) != m_flags || int'(pc_load) != m_load || int'(pc_value) != m_pc) begin
      n_fail++;
      $display("FAIL %s: flags=%03h load=%0d pc=%06h expected flags=%03h load=%0d pc=%06h",
               req, flags, pc_load, pc_value, m_flags, m_load, m_pc);
    end
  endtask

  task automatic clear_in();
    {ev_por, ev_bor, ev_ext, ev_swrst, ev_wdt_to, ev_trapc, ev_illop,
     ev_clkfail, ev_wdt_wake, ev_int_wake, sw_we} = '0;
  endtask

  // apply current inputs for one edge, then compare at the falling edge
  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    clear_in();
    check(req);
  endtask

  task automatic write_flags(input int v);
    sw_we = 1; sw_wdata = 9'(v); step("R2");
  endtask

  initial begin
    #(8 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    ev_por = 1; write_flags(0); // write lost behind por: R12
    ev_por = 1; step("R3");
    write_flags(9'h1FE);
    ev_por = 1; step("R3");
    write_flags(9'h0F5);
    ev_bor = 1; step("R4");
    for (int md = 0; md < 4; md++) begin
      write_flags(9'h078);
      core_mode = 2'(md); ev_ext = 1; step("R5");
    end
    core_mode = 0;
    write_flags(9'h074); ev_swrst = 1; step("R6");
    write_flags(9'h06C); ev_wdt_to = 1; step("R7");
    write_flags(9'h100); cur_pc = 24'h001230; ev_wdt_wake = 1; step("R8");
    cur_pc = 24'hFFFFFE; ev_wdt_wake = 1; step("R13");
    int_enabled = 1; int_vector = 24'h000A40; ev_int_wake = 1; step("R9");
    int_enabled = 0; cur_pc = 24'h000500; ev_int_wake = 1; step("R9");
    write_flags(9'h1AA); ev_clkfail = 1; step("R10");
    step("R13");
    step("R13");
    write_flags(9'h000); ev_trapc = 1; step("R11");
    ev_illop = 1; step("R11");
    ev_bor = 1; ev_ext = 1; step("R12");
    ev_ext = 1; ev_swrst = 1; core_mode = 2; step("R12");
    ev_clkfail = 1; ev_wdt_wake = 1; step("R12");
    ev_illop = 1; ev_clkfail = 1; step("R12");
    ev_wdt_wake = 1; ev_int_wake = 1; int_enabled = 1; step("R12");
    sw_we = 1; sw_wdata = 9'h1FF; ev_int_wake = 1; step("R12");

    for (int i = 0; i < 2000; i++) begin
      ev_por      = ($urandom % 40) == 0;
      ev_bor      = ($urandom % 25) == 0;
      ev_ext      = ($urandom % 12) == 0;
      ev_swrst    = ($urandom % 12) == 0;
      ev_wdt_to   = ($urandom % 12) == 0;
      ev_trapc    = ($urandom % 12) == 0;
      ev_illop    = ($urandom % 12) == 0;
      ev_clkfail  = ($urandom % 12) == 0;
      ev_wdt_wake = ($urandom % 10) == 0;
      ev_int_wake = ($urandom % 10) == 0;
      core_mode   = 2'($urandom);
      cur_pc      = PC_W'($urandom);
      int_enabled = 1'($urandom);
      int_vector  = PC_W'($urandom);
      sw_we       = ($urandom % 3) == 0;
      sw_wdata    = 9'($urandom);
      step("R12");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule